// File: doc/BRIEF.md
# Dual-Field Word Multiplier

This block multiplies two unsigned words of the same width in a single pass. It works in one of two arithmetic fields. In integer mode it returns the ordinary product, which suits modular arithmetic over a prime field. In polynomial mode it returns the carry-less product, where partial products are combined by XOR only, which suits arithmetic over a binary extension field. The word width is a parameter from 8 to 64 bits, with a default of 16, so the core can sit directly on a system bus of that width. A surrounding controller builds long-operand Montgomery multiplication out of repeated word products.

Both modes share one partial-product array and one reduction network. Each column of partial-product bits is reduced by a tree of half and full adders whose sum outputs stay in the column. This "non-carry" tree therefore ends in the XOR of the column, which is the polynomial product bit. The carries produced by that tree are sent to a separate carry tree, which compresses them to two rows. In integer mode one 3:2 layer and one carry-propagate adder fold the carry rows into the XOR row. In polynomial mode the carry rows are forced to zero, so the same adder passes the XOR row through unchanged. An optional output register, selected by a parameter, captures the product together with a valid flag.

Top module: `dfmul_core`

## Requirements
- R1: With `mode_i` = 0 (integer), the result equals the unsigned product `opa_i * opb_i`, all 2·WORD_W bits.
- R2: With `mode_i` = 1 (polynomial), result bit k equals the XOR over all i+j=k of `opa_i[i] & opb_i[j]`. Bit 2·WORD_W−1 is always 0.
- R3: If either operand is zero, the result is zero in both modes.
- R4: All-ones operands give (2^WORD_W − 1)^2 in integer mode, and the carry-less square of the all-ones word in polynomial mode.
- R5: An operand equal to 1 returns the other operand, zero-extended, in both modes.
- R6: With the output register enabled (REG_OUT = 1), the result of an operation issued with `issue_i` high appears on `prod_o`, with `valid_o` high, one clock edge later.
- R7: After a cycle in which `issue_i` is low, `valid_o` is low, and `prod_o` keeps the last result.
- R8: While `rst_n` is low, `prod_o` and `valid_o` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| issue_i | input | 1 | Operand pair is valid this cycle |
| mode_i | input | 1 | 0 = integer product, 1 = carry-less polynomial product |
| opa_i | input | WORD_W | First operand |
| opb_i | input | WORD_W | Second operand |
| prod_o | output | 2·WORD_W | Product |
| valid_o | output | 1 | Product on `prod_o` belongs to an operation issued in the previous cycle |

## Verification
Some faults corrupt the non-carry tree, for example a full adder that loses a sum bit or a column that is wired wrong. These show up in both modes on the very next valid result, as soon as an operand pattern puts ones into the affected column. A fault in the carry tree or in the final adder leaves polynomial results correct and spoils only integer results. Most such faults appear only for operand pairs whose partial products pile up enough ones in a column, so the whole operand space of a narrow word is swept in both modes. A fault in the mode gating makes polynomial results pick up carries. The earliest operand pair that produces a carry exposes it; 3 × 3 is one example.

// File: rtl/dfmul_pkg.sv
package dfmul_pkg;

   typedef enum logic {
      MODE_INT  = 1'b0,
      MODE_POLY = 1'b1
   } dfmul_mode_e;

   // Carries emitted when an n-bit column is reduced to one bit by a
   // 3:2 / 2:2 tree. Every adder leaves one bit in the column and
   // sends one carry out.
   function automatic int fa_carry_count(input int n);
      int cnt;
      int k;
      cnt = n;
      k   = 0;
      for (int i = 0; i < n; i++) begin
         if (cnt > 1) begin
            if (cnt == 2) begin
               k   = k + 1;
               cnt = 1;
            end else begin
               k   = k + cnt / 3;
               cnt = cnt / 3 + cnt % 3;
            end
         end
      end
      return k;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dfmul_ppgen.sv
module dfmul_ppgen #(
   parameter int W = 16,
   localparam int COLS = 2 * W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] col_o [COLS]
);

   // Column c slot i holds a[i] & b[c-i], or zero when c-i is outside the word.
   for (genvar c = 0; c < COLS; c++) begin : g_col
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam int J = c - i;
         if (J >= 0 && J < W) begin : g_and
            assign col_o[c][i] = a_i[i] & b_i[J];
         end else begin : g_zero
            assign col_o[c][i] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/dfmul_xor_tree.sv
module dfmul_xor_tree
   import dfmul_pkg::*;
#(
   parameter int N = 16,
   localparam int K = fa_carry_count(N)
) (
   input  logic [N-1:0] bits_i,
   output logic         sum_o,
   output logic [K-1:0] carry_o
);

   // Level-by-level 3:2 reduction. Sums stay in the column, so the
   // surviving bit is the XOR of the column; every carry leaves.
   always_comb begin
      logic [N-1:0] work;
      logic [N-1:0] nxt_work;
      logic [K-1:0] cy;
      int           cnt;
      int           nxt;
      int           ci;
      work = bits_i;
      cy   = '0;
      cnt  = N;
      ci   = 0;
      for (int lvl = 0; lvl < N; lvl++) begin
         if (cnt > 1) begin
            nxt_work = '0;
            nxt      = 0;
            if (cnt == 2) begin
               nxt_work[0] = work[0] ^ work[1];
               cy[ci]      = work[0] & work[1];
               ci          = ci + 1;
               nxt         = 1;
            end else begin
               for (int g = 0; g < N; g += 3) begin
                  if (g + 2 < cnt) begin
                     nxt_work[nxt] = work[g] ^ work[g+1] ^ work[g+2];
                     cy[ci]        = (work[g] & work[g+1]) | (work[g] & work[g+2])
                                   | (work[g+1] & work[g+2]);
                     ci            = ci + 1;
                     nxt           = nxt + 1;
                  end else if (g < cnt) begin
                     nxt_work[nxt] = work[g];
                     nxt           = nxt + 1;
                     if (g + 1 < cnt) begin
                        nxt_work[nxt] = work[g+1];
                        nxt           = nxt + 1;
                     end
                  end
               end
            end
            work = nxt_work;
            cnt  = nxt;
         end
      end
      sum_o   = work[0];
      carry_o = cy;
   end

endmodule

// File: rtl/dfmul_carry_tree.sv
module dfmul_carry_tree
   import dfmul_pkg::*;
#(
   parameter int COLS = 32,
   parameter int K    = 8,
   localparam int H   = K + 2
) (
   input  logic [K-1:0]    cin_i [COLS],
   output logic [COLS-1:0] row_a_o,
   output logic [COLS-1:0] row_b_o
);

   // Multi-column carry-save compression down to two rows. Carries out
   // of the top column fall beyond the 2W-bit product and are dropped.
   always_comb begin
      logic [H-1:0] m  [COLS];
      logic [H-1:0] mn [COLS];
      int           h  [COLS];
      int           hn [COLS];
      for (int c = 0; c < COLS; c++) begin
         m[c] = '0;
         m[c][K-1:0] = cin_i[c];
         h[c] = K;
      end
      for (int lvl = 0; lvl < H + 2; lvl++) begin
         for (int c = 0; c < COLS; c++) begin
            mn[c] = '0;
            hn[c] = 0;
         end
         for (int c = 0; c < COLS; c++) begin
            if (h[c] > 2) begin
               for (int g = 0; g < H; g += 3) begin
                  if (g + 2 < h[c]) begin
                     mn[c][hn[c]] = m[c][g] ^ m[c][g+1] ^ m[c][g+2];
                     hn[c] = hn[c] + 1;
                     if (c + 1 < COLS) begin
                        mn[c+1][hn[c+1]] = (m[c][g] & m[c][g+1]) | (m[c][g] & m[c][g+2])
                                         | (m[c][g+1] & m[c][g+2]);
                        hn[c+1] = hn[c+1] + 1;
                     end
                  end else if (g < h[c]) begin
                     mn[c][hn[c]] = m[c][g];
                     hn[c] = hn[c] + 1;
                     if (g + 1 < h[c]) begin
                        mn[c][hn[c]] = m[c][g+1];
                        hn[c] = hn[c] + 1;
                     end
                  end
               end
            end else begin
               for (int g = 0; g < 2; g++) begin
                  if (g < h[c]) begin
                     mn[c][hn[c]] = m[c][g];
                     hn[c] = hn[c] + 1;
                  end
               end
            end
         end
         for (int c = 0; c < COLS; c++) begin
            m[c] = mn[c];
            h[c] = hn[c];
         end
      end
      for (int c = 0; c < COLS; c++) begin
         row_a_o[c] = m[c][0];
         row_b_o[c] = m[c][1];
      end
   end

endmodule

// File: rtl/dfmul_core.sv
module dfmul_core
   import dfmul_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  issue_i,
   input  logic                  mode_i,
   input  logic [WORD_W-1:0]     opa_i,
   input  logic [WORD_W-1:0]     opb_i,
   output logic [2*WORD_W-1:0]   prod_o,
   output logic                  valid_o
);

   localparam int PW = 2 * WORD_W;
   localparam int K  = fa_carry_count(WORD_W);

   if (WORD_W < 8 || WORD_W > 64) begin : g_bad_width
      $error("dfmul_core: WORD_W must lie in 8..64");
   end

   logic [WORD_W-1:0] pp_col [PW];
   logic [K-1:0]      col_cy [PW];
   logic [K-1:0]      cy_in  [PW];
   logic [PW-1:0]     xor_row;
   logic [PW-1:0]     row_a, row_b;
   logic [PW-1:0]     gate_a, gate_b;
   logic [PW-1:0]     fold_s, fold_c;
   logic [PW-1:0]     prod_comb;
   logic              int_mode;

   dfmul_ppgen #(.W(WORD_W)) u_ppgen (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .col_o (pp_col)
   );

   // Non-carry tree: one column reducer per product bit.
   for (genvar c = 0; c < PW; c++) begin : g_xcol
      dfmul_xor_tree #(.N(WORD_W)) u_xt (
         .bits_i  (pp_col[c]),
         .sum_o   (xor_row[c]),
         .carry_o (col_cy[c])
      );
      if (c == 0) begin : g_c0
         assign cy_in[c] = '0;
      end else begin : g_cn
         assign cy_in[c] = col_cy[c-1];
      end
   end

   dfmul_carry_tree #(.COLS(PW), .K(K)) u_ctree (
      .cin_i   (cy_in),
      .row_a_o (row_a),
      .row_b_o (row_b)
   );

   // Polynomial mode silences the carry tree; the adder then passes the XOR row.
   assign int_mode = (dfmul_mode_e'(mode_i) == MODE_INT);
   assign gate_a   = row_a & {PW{int_mode}};
   assign gate_b   = row_b & {PW{int_mode}};

   assign fold_s    = xor_row ^ gate_a ^ gate_b;
   assign fold_c    = {((xor_row[PW-2:0] & gate_a[PW-2:0]) | (xor_row[PW-2:0] & gate_b[PW-2:0])
                       | (gate_a[PW-2:0] & gate_b[PW-2:0])), 1'b0};
   assign prod_comb = fold_s + fold_c;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prod_o  <= '0;
            valid_o <= 1'b0;
         end else begin
            valid_o <= issue_i;
            if (issue_i) begin
               prod_o <= prod_comb;
            end
         end
      end
   end else begin : g_comb
      assign prod_o  = prod_comb;
      assign valid_o = issue_i;
   end

endmodule

// File: rtl/dfmul_core_chk.sv
module dfmul_core_chk #(
   parameter int WORD_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                issue_i,
   input logic                mode_i,
   input logic [WORD_W-1:0]   opa_i,
   input logic [WORD_W-1:0]   opb_i,
   input logic [2*WORD_W-1:0] prod_o,
   input logic                valid_o
);

   if (REG_OUT) begin : g_chk
      // R6
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_i |=> valid_o);
      // R7
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !issue_i |=> !valid_o);
      // R7
      prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !issue_i |=> $stable(prod_o));
      // R2
      poly_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_i && mode_i) |=> !prod_o[2*WORD_W-1]);
      // R3
      zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_i && (opa_i == '0 || opb_i == '0)) |=> (prod_o == '0));
      // R5
      unit_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_i && opa_i == WORD_W'(1)) |=> (prod_o == {{WORD_W{1'b0}}, $past(opb_i)}));
   end

endmodule

bind dfmul_core dfmul_core_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .issue_i (issue_i),
   .mode_i  (mode_i),
   .opa_i   (opa_i),
   .opb_i   (opb_i),
   .prod_o  (prod_o),
   .valid_o (valid_o)
);

// File: tb/tb_dfmul_core.sv
module tb_dfmul_core;

   localparam int W  = 8;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          issue;
   logic          mode;
   logic [W-1:0]  opa, opb;
   logic [PW-1:0] prod;
   logic          valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dfmul_core #(.WORD_W(W), .REG_OUT(1'b1)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_i (issue),
      .mode_i  (mode),
      .opa_i   (opa),
      .opb_i   (opb),
      .prod_o  (prod),
      .valid_o (valid)
   );

   function automatic logic [PW-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [PW-1:0] acc;
      acc = '0;
      for (int i = 0; i < W; i++) begin
         if (a[i]) acc = acc ^ (PW'(b) << i);
      end
      return acc;
   endfunction

   task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      logic [PW-1:0] last_exp;
      rst_n = 1'b0;
      issue = 1'b0;
      mode  = 1'b0;
      opa   = '0;
      opb   = '0;
      last_exp = '0;
      repeat (3) @(negedge clk);
      chk("R8 prod", prod, '0);
      chk("R8 valid", PW'(valid), '0);
      rst_n = 1'b1;

      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
               logic [PW-1:0] exp;
               string         tag;
               issue = 1'b1;
               mode  = m[0];
               opa   = W'(a);
               opb   = W'(b);
               exp   = (m == 0) ? PW'(a * b) : clmul(W'(a), W'(b));
               if (a == 0 || b == 0)                        tag = "R3";
               else if (a == (1 << W) - 1 && b == (1 << W) - 1) tag = "R4";
               else if (a == 1 || b == 1)                   tag = "R5";
               else                                         tag = (m == 0) ? "R1" : "R2";
               @(negedge clk);
               chk(tag, prod, exp);
               if (a == 37 && b == 5) chk("R6 valid", PW'(valid), PW'(1));
               last_exp = exp;
            end
         end
      end

      issue = 1'b0;
      opa   = '1;
      opb   = '1;
      mode  = 1'b0;
      @(negedge clk);
      chk("R7 valid", PW'(valid), '0);
      chk("R7 hold", prod, last_exp);
      @(negedge clk);
      chk("R7 hold2", prod, last_exp);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule